// File: doc/BRIEF.md
# GF(2^163) Polynomial Reducer with Squaring Path

This block reduces binary polynomials to elements of the field GF(2^163), using the field polynomial f(x) = x^163 + x^7 + x^6 + x^3 + 1. A 325-bit input represents a product of two field elements before reduction, with bit i holding the coefficient of x^i. The block returns the 163-bit remainder of that input modulo f(x). The reduction is a fixed network of XOR gates and contains no loop or state machine.

A second path squares a field element. It spreads the 163 input bits into a 325-bit polynomial, with zeros in the odd positions, and sends that polynomial through its own copy of the same reducer. An arithmetic unit can place the block after a carry-less multiplier and beside its register file. A parameter sets whether the two results are registered or combinational.

Top module: `gf163_reducer`

## Requirements
- R1: When registered outputs are selected (REG_OUT=1), a clock edge with the synchronous active-high `rst` high sets both `r_out` and `sq_out` to zero.
- R2: `r_out` equals d_in(x) mod (x^163 + x^7 + x^6 + x^3 + 1) for every 325-bit `d_in`, where bit i of a vector is the coefficient of x^i. An all-zero `d_in` gives a zero `r_out`.
- R3: A `d_in` that has no set bit at position 163 or above appears unchanged in `r_out`.
- R4: A `d_in` that has only bit 163 set gives `r_out` = 0xC9, which means bits 0, 3, 6 and 7 are set and all other bits are clear.
- R5: `sq_out` equals sq_in(x)·sq_in(x) mod f(x) for every 163-bit `sq_in`.
- R6: A `sq_in` that has no set bit at position 82 or above gives `sq_out` bit 2i equal to `sq_in` bit i, and every odd bit of `sq_out` is zero.
- R7: With REG_OUT=1, both outputs show the result for the inputs present at the previous rising clock edge. Inputs may change on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output registers |
| rst | input | 1 | Synchronous active-high reset |
| d_in | input | 325 | Unreduced polynomial, bit i is the coefficient of x^i |
| sq_in | input | 163 | Field element to be squared |
| r_out | output | 163 | Remainder of `d_in` modulo f(x) |
| sq_out | output | 163 | Reduced square of `sq_in` |

## Verification
The bench builds the block with its defaults: M=163 and REG_OUT=1. These values bring the one-cycle registered timing and the reset clear within reach, along with both fold stages of the 163-bit field.

A set bit is walked through all 325 input positions. This exercises every fold tap, including the second fold that bits 319 to 324 cause. A single set bit is also walked through all 163 squaring positions, so that upper input bits spread past bit 162 and must fold back.

Random operands arrive back to back on every cycle and are compared against a long-division model and a carry-less self-multiplication model.

// File: rtl/gf2m_pkg.sv
package gf2m_pkg;
  localparam int FIELD_M = 163;
  // lower part of the field polynomial: x^7 + x^6 + x^3 + 1
  localparam int TAP_SPAN = 8;
  localparam logic [TAP_SPAN-1:0] LOW_TAPS = 8'b1100_1001;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/gf2m_fold.sv
// One folding pass: bits at and above M are multiplied by the low taps
// and added into the low part, using x^M == low taps.
module gf2m_fold #(
  parameter int M  = 163,
  parameter int IW = 325,
  parameter int TS = 8,
  parameter logic [TS-1:0] TAPS = 8'b1100_1001,
  localparam int HW = IW - M,
  localparam int OW = gf2m_pkg::imax(M, HW + TS - 1)
) (
  input  logic [IW-1:0] a,
  output logic [OW-1:0] y
);
  always_comb begin
    y = '0;
    y[M-1:0] = a[M-1:0];
    for (int k = 0; k < TS; k++) begin
      if (TAPS[k]) y[k +: HW] = y[k +: HW] ^ a[IW-1:M];
    end
  end
endmodule

// File: rtl/gf2m_reduce.sv
// Two chained folds: the first leaves at most TS-1 excess bits,
// and the second folds those into the field width.
module gf2m_reduce #(
  parameter int M  = 163,
  parameter int TS = 8,
  parameter logic [TS-1:0] TAPS = 8'b1100_1001,
  localparam int DW = 2*M - 1,
  localparam int W1 = gf2m_pkg::imax(M, (M - 1) + TS - 1),
  localparam int W2 = gf2m_pkg::imax(M, (W1 - M) + TS - 1)
) (
  input  logic [DW-1:0] d,
  output logic [M-1:0]  r
);
  logic [W1-1:0] s1;
  logic [W2-1:0] s2;

  gf2m_fold #(.M(M), .IW(DW), .TS(TS), .TAPS(TAPS)) u_fold_hi (.a(d),  .y(s1));
  gf2m_fold #(.M(M), .IW(W1), .TS(TS), .TAPS(TAPS)) u_fold_lo (.a(s1), .y(s2));

  assign r = s2[M-1:0];
endmodule

// File: rtl/gf2m_spread.sv
// Squaring over GF(2) before reduction: bit i moves to bit 2i.
module gf2m_spread #(
  parameter int M = 163,
  localparam int DW = 2*M - 1
) (
  input  logic [M-1:0]  a,
  output logic [DW-1:0] y
);
  for (genvar i = 0; i < M; i++) begin : g_bit
    assign y[2*i] = a[i];
    if (i < M - 1) begin : g_gap
      assign y[2*i+1] = 1'b0;
    end
  end
endmodule

// File: rtl/gf163_reducer.sv
module gf163_reducer #(
  parameter int M       = gf2m_pkg::FIELD_M,
  parameter bit REG_OUT = 1'b1,
  localparam int DW = 2*M - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] d_in,
  input  logic [M-1:0]  sq_in,
  output logic [M-1:0]  r_out,
  output logic [M-1:0]  sq_out
);
  localparam int TS = gf2m_pkg::TAP_SPAN;
  localparam logic [TS-1:0] TAPS = gf2m_pkg::LOW_TAPS;

  logic [DW-1:0] sq_wide;
  logic [M-1:0]  r_comb;
  logic [M-1:0]  sq_comb;

  gf2m_spread #(.M(M)) u_spread (.a(sq_in), .y(sq_wide));

  gf2m_reduce #(.M(M), .TS(TS), .TAPS(TAPS)) u_red_mul (.d(d_in),    .r(r_comb));
  gf2m_reduce #(.M(M), .TS(TS), .TAPS(TAPS)) u_red_sq  (.d(sq_wide), .r(sq_comb));

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        r_out  <= '0;
        sq_out <= '0;
      end else begin
        r_out  <= r_comb;
        sq_out <= sq_comb;
      end
    end
  end else begin : g_comb
    assign r_out  = r_comb;
    assign sq_out = sq_comb;
  end
endmodule

// File: rtl/gf163_reducer_chk.sv
module gf163_reducer_chk #(
  parameter int M       = 163,
  parameter bit REG_OUT = 1'b1,
  localparam int DW = 2*M - 1,
  localparam int HALF = (M + 1) / 2
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] d_in,
  input logic [M-1:0]  sq_in,
  input logic [M-1:0]  r_out,
  input logic [M-1:0]  sq_out
);
  localparam logic [DW-1:0] X_TOP  = DW'(1) << M;
  localparam logic [M-1:0]  X_FOLD = M'(8'hC9);

  function automatic logic [M-1:0] spread_low(input logic [M-1:0] a);
    logic [M-1:0] v;
    v = '0;
    for (int i = 0; i < HALF; i++) v[2*i] = a[i];
    return v;
  endfunction

  if (REG_OUT) begin : g_seq
    AST_RST_CLEAR: assert property (@(posedge clk)
      rst |=> (r_out == '0 && sq_out == '0)); // R1
    AST_ZERO_IN: assert property (@(posedge clk) disable iff (rst)
      (d_in == '0) |=> (r_out == '0)); // R2
    AST_LOW_PASS: assert property (@(posedge clk) disable iff (rst)
      (d_in[DW-1:M] == '0) |=> (r_out == $past(d_in[M-1:0]))); // R3
    AST_X163_FOLD: assert property (@(posedge clk) disable iff (rst)
      (d_in == X_TOP) |=> (r_out == X_FOLD)); // R4
    AST_SQ_SPREAD: assert property (@(posedge clk) disable iff (rst)
      (sq_in[M-1:HALF] == '0) |=> (sq_out == spread_low($past(sq_in)))); // R6
  end else begin : g_cmb
    AST_ZERO_IN: assert property (@(posedge clk) disable iff (rst)
      (d_in == '0) |-> (r_out == '0)); // R2
    AST_LOW_PASS: assert property (@(posedge clk) disable iff (rst)
      (d_in[DW-1:M] == '0) |-> (r_out == d_in[M-1:0])); // R3
    AST_X163_FOLD: assert property (@(posedge clk) disable iff (rst)
      (d_in == X_TOP) |-> (r_out == X_FOLD)); // R4
    AST_SQ_SPREAD: assert property (@(posedge clk) disable iff (rst)
      (sq_in[M-1:HALF] == '0) |-> (sq_out == spread_low(sq_in))); // R6
  end
endmodule

bind gf163_reducer gf163_reducer_chk #(.M(M), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst(rst), .d_in(d_in), .sq_in(sq_in), .r_out(r_out), .sq_out(sq_out)
);

// File: tb/tb_gf163_reducer.sv
`timescale 1ns/1ps
module tb_gf163_reducer;
  localparam int M  = 163;
  localparam int DW = 2*M - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] d_in = '0;
  logic [M-1:0]  sq_in = '0;
  logic [M-1:0]  r_out, sq_out;

  int checks = 0;
  int fails  = 0;

  logic [M-1:0] exp_r, exp_s;
  string        cur_tag;
  bit           have_prev = 1'b0;

  always #4 clk = ~clk;

  gf163_reducer #(.M(M), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst(rst), .d_in(d_in), .sq_in(sq_in), .r_out(r_out), .sq_out(sq_out)
  );

  // long division by f(x) = x^163 + x^7 + x^6 + x^3 + 1
  function automatic logic [M-1:0] ref_mod(input logic [DW-1:0] p);
    logic [DW-1:0] f;
    f = '0;
    f[163] = 1'b1; f[7] = 1'b1; f[6] = 1'b1; f[3] = 1'b1; f[0] = 1'b1;
    for (int i = DW - 1; i >= M; i--) begin
      if (p[i]) p = p ^ (f << (i - M));
    end
    return p[M-1:0];
  endfunction

  function automatic logic [DW-1:0] clmul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [DW-1:0] acc;
    acc = '0;
    for (int i = 0; i < M; i++) begin
      if (b[i]) acc = acc ^ (DW'(a) << i);
    end
    return acc;
  endfunction

  function automatic logic [DW-1:0] rand_wide();
    logic [DW-1:0] v;
    v = '0;
    for (int w = 0; w < 11; w++) v = (v << 32) | DW'($urandom);
    return v;
  endfunction

  task automatic check_vec(input string tag, input string what,
                           input logic [M-1:0] act, input logic [M-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One cycle: check the result of the previous inputs (R7 latency), then drive new ones
  task automatic step(input logic [DW-1:0] d, input logic [M-1:0] s, input string tag);
    @(negedge clk);
    if (have_prev) begin
      check_vec({cur_tag, " R7"}, "r_out", r_out, exp_r);
      check_vec({cur_tag, " R7 R5"}, "sq_out", sq_out, exp_s);
    end
    d_in    = d;
    sq_in   = s;
    exp_r   = ref_mod(d);
    exp_s   = ref_mod(clmul(s, s));
    cur_tag = tag;
    have_prev = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    logic [M-1:0]  e;
    repeat (3) @(negedge clk);
    check_vec("R1", "r_out", r_out, '0);
    check_vec("R1", "sq_out", sq_out, '0);
    rst = 1'b0;

    step('0, '0, "R2");
    // low-only inputs pass unchanged
    for (int n = 0; n < 20; n++) begin
      v = rand_wide();
      v[DW-1:M] = '0;
      step(v, M'(rand_wide()) & {{(M-82){1'b0}}, {82{1'b1}}}, "R3 R6");
    end
    // the x^163 fold
    step(DW'(1) << M, '0, "R4");
    @(negedge clk);
    check_vec("R4", "r_out", r_out, M'(8'hC9));
    have_prev = 1'b0;
    // single set bit walked through every input position
    for (int i = 0; i < DW; i++) step(DW'(1) << i, '0, "R2");
    for (int i = 0; i < M; i++) step('0, M'(1) << i, "R5");
    // random back-to-back operands
    for (int n = 0; n < 300; n++) step(rand_wide(), M'(rand_wide()), "R2 R5");
    step({DW{1'b1}}, {M{1'b1}}, "R2 R5");
    step('0, '0, "R2");

    // reset in the middle of a stream
    @(negedge clk);
    rst = 1'b1;
    d_in = rand_wide();
    sq_in = M'(rand_wide());
    have_prev = 1'b0;
    @(negedge clk);
    check_vec("R1", "r_out", r_out, '0);
    check_vec("R1", "sq_out", sq_out, '0);
    rst = 1'b0;
    e = ref_mod(d_in);
    @(negedge clk);
    check_vec("R7", "r_out", r_out, e);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule